// File: doc/BRIEF.md
# Two-Level LRU Tag Hierarchy

This block keeps the tags of a two-level cache. Both levels are fully associative. The first level is small and the second level is a little larger. Each level keeps its block addresses in recency order, and replacement in each level is true least-recently-used. Data, writes, memory latency and coherence are not modelled. Only block addresses and their order are tracked.

A request carries one block address. The block looks the address up in the first level. It consults the second level only when the first level misses. One cycle after the request, the block returns a response that names exactly one outcome: first-level hit, second-level hit, or miss in both. The same clock edge updates the order of both levels. A debug port shows each level's entries from most to least recently used, so a checker can follow the whole hierarchy cycle by cycle.

Top module: `two_level_lru_tags`

## Requirements
- R1: After reset, every valid flag on both debug ports is 0, so both levels are empty.
- R2: A request whose address is valid in the first level reports a first-level hit. The address moves to first-level entry 0, and the entries that were ahead of it each shift back by one place. The second level's addresses and valid flags stay exactly as they were.
- R3: The response arrives in the cycle after a request is accepted. In that cycle rsp_valid is 1 and exactly one of rsp_l1_hit, rsp_l2_hit and rsp_miss is 1. In a cycle with no request in the cycle before, all four response outputs are 0.
- R4: A request that misses the first level but is valid in the second level reports a second-level hit. The address is inserted at first-level entry 0 and also moves to second-level entry 0.
- R5: A request that misses both levels reports a miss. The address is inserted at entry 0 of both levels.
- R6: When a level is full and must take a new block, its last entry (the LRU one) is discarded. A block pushed out of the first level is dropped and is not written into the second level.
- R7: Empty entries are used before any valid entry is evicted. The valid entries of a level always occupy entries 0 upward with no gap.
- R8: In the debug ports, entry i of a level occupies address bits [16*i+15:16*i] and valid bit i, where entry 0 is MRU and higher entries are older. No valid block address appears twice within one level.
- R9: In a cycle with req_valid at 0, neither level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 16 | Block address of the request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_l1_hit | output | 1 | That request hit the first level |
| rsp_l2_hit | output | 1 | That request missed the first level and hit the second level |
| rsp_miss | output | 1 | That request missed both levels |
| dbg_l1_addr | output | 32 | First-level addresses, entry 0 (MRU) in the low bits |
| dbg_l1_valid | output | 2 | First-level valid flag for each entry |
| dbg_l2_addr | output | 48 | Second-level addresses, entry 0 (MRU) in the low bits |
| dbg_l2_valid | output | 3 | Second-level valid flag for each entry |

## Verification
The bench targets four behaviours, each with a known wrong-design symptom.

- A first-level hit must leave the second level untouched. A design that also refreshes the second level would show a changed second-level order after such a hit.
- A second-level hit must reorder the second level as well as fill the first. A design that only fills the first level would leave a stale order and later evict the wrong second-level victim.
- A directed sequence pushes a block out of the first level and then requests it again. The response must be a second-level hit, or a miss if that level has evicted it too. A design that writes first-level victims back, or fills at the wrong end, would then report the wrong outcome or show the wrong order.
- Random traffic over a small address pool keeps both levels full and churning. This exposes any duplicate entry, gap in the valid flags, or response with more or fewer than one outcome flag.

// File: rtl/two_level_lru_tags.sv
module two_level_lru_tags #(
  parameter int AW      = 16,
  parameter int L1_WAYS = 2,
  parameter int L2_WAYS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [AW-1:0]           req_addr,
  output logic                    rsp_valid,
  output logic                    rsp_l1_hit,
  output logic                    rsp_l2_hit,
  output logic                    rsp_miss,
  output logic [L1_WAYS*AW-1:0]   dbg_l1_addr,
  output logic [L1_WAYS-1:0]      dbg_l1_valid,
  output logic [L2_WAYS*AW-1:0]   dbg_l2_addr,
  output logic [L2_WAYS-1:0]      dbg_l2_valid
);
  localparam int P1 = (L1_WAYS > 1) ? $clog2(L1_WAYS) : 1;
  localparam int P2 = (L2_WAYS > 1) ? $clog2(L2_WAYS) : 1;

  logic [AW-1:0]      l1_a [L1_WAYS];
  logic [AW-1:0]      l2_a [L2_WAYS];
  logic [L1_WAYS-1:0] l1_v, l1_m;
  logic [L2_WAYS-1:0] l2_v, l2_m;
  logic [P1-1:0]      l1_pos;
  logic [P2-1:0]      l2_pos;
  logic               l1_any, l2_any, upd_l2;

  for (genvar i = 0; i < L1_WAYS; i++) begin : g_l1
    assign l1_m[i] = l1_v[i] && (l1_a[i] == req_addr);
    assign dbg_l1_addr[i*AW +: AW] = l1_a[i];
  end
  for (genvar i = 0; i < L2_WAYS; i++) begin : g_l2
    assign l2_m[i] = l2_v[i] && (l2_a[i] == req_addr);
    assign dbg_l2_addr[i*AW +: AW] = l2_a[i];
  end

  assign l1_any       = |l1_m;
  assign l2_any       = |l2_m;
  assign upd_l2       = req_valid && !l1_any;
  assign dbg_l1_valid = l1_v;
  assign dbg_l2_valid = l2_v;

  // Shift boundary: the hit entry, or the LRU slot when the level misses.
  always_comb begin
    l1_pos = P1'(L1_WAYS - 1);
    for (int i = L1_WAYS - 1; i >= 0; i--)
      if (l1_m[i]) l1_pos = P1'(i);
  end
  always_comb begin
    l2_pos = P2'(L2_WAYS - 1);
    for (int i = L2_WAYS - 1; i >= 0; i--)
      if (l2_m[i]) l2_pos = P2'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l1_v <= '0;
      for (int i = 0; i < L1_WAYS; i++) l1_a[i] <= '0;
    end else if (req_valid) begin
      l1_a[0] <= req_addr;
      l1_v[0] <= 1'b1;
      for (int i = 1; i < L1_WAYS; i++)
        if (i <= int'(l1_pos)) begin
          l1_a[i] <= l1_a[i-1];
          l1_v[i] <= l1_v[i-1];
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l2_v <= '0;
      for (int i = 0; i < L2_WAYS; i++) l2_a[i] <= '0;
    end else if (upd_l2) begin
      l2_a[0] <= req_addr;
      l2_v[0] <= 1'b1;
      for (int i = 1; i < L2_WAYS; i++)
        if (i <= int'(l2_pos)) begin
          l2_a[i] <= l2_a[i-1];
          l2_v[i] <= l2_v[i-1];
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_l1_hit <= 1'b0;
      rsp_l2_hit <= 1'b0;
      rsp_miss   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_l1_hit <= req_valid && l1_any;
      rsp_l2_hit <= upd_l2 && l2_any;
      rsp_miss   <= upd_l2 && !l2_any;
    end
  end

  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_l1_hit, rsp_l2_hit, rsp_miss}) == 1);
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_l1_hit || rsp_l2_hit || rsp_miss));
  p_rsp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_mru_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dbg_l1_valid[0] && dbg_l1_addr[AW-1:0] == $past(req_addr));
  p_l2_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_l1_hit |-> $stable(dbg_l2_addr) && $stable(dbg_l2_valid));
  p_l2_mru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_l2_hit || rsp_miss) |-> dbg_l2_valid[0] && dbg_l2_addr[AW-1:0] == dbg_l1_addr[AW-1:0]);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(dbg_l1_addr) && $stable(dbg_l2_addr) && $stable(dbg_l1_valid) && $stable(dbg_l2_valid));
  p_packed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((l1_v & (l1_v + 1'b1)) == '0) && ((l2_v & (l2_v + 1'b1)) == '0));

  for (genvar i = 0; i < L1_WAYS; i++) begin : g_d1
    for (genvar j = i + 1; j < L1_WAYS; j++) begin : g_d1j
      p_nodup_l1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(l1_v[i] && l1_v[j] && l1_a[i] == l1_a[j]));
    end
  end
  for (genvar i = 0; i < L2_WAYS; i++) begin : g_d2
    for (genvar j = i + 1; j < L2_WAYS; j++) begin : g_d2j
      p_nodup_l2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(l2_v[i] && l2_v[j] && l2_a[i] == l2_a[j]));
    end
  end
endmodule

// File: tb/tb_two_level_lru_tags.sv
module tb_two_level_lru_tags;
  localparam int AW = 16, W1 = 2, W2 = 3;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_valid, rsp_l1_hit, rsp_l2_hit, rsp_miss;
  logic [W1*AW-1:0] dbg_l1_addr;
  logic [W1-1:0]    dbg_l1_valid;
  logic [W2*AW-1:0] dbg_l2_addr;
  logic [W2-1:0]    dbg_l2_valid;

  int n_cmp = 0, n_bad = 0;
  logic [AW-1:0] q1[$], q2[$];

  always #5 clk = ~clk;

  two_level_lru_tags #(.AW(AW), .L1_WAYS(W1), .L2_WAYS(W2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_l1_hit(rsp_l1_hit), .rsp_l2_hit(rsp_l2_hit),
    .rsp_miss(rsp_miss), .dbg_l1_addr(dbg_l1_addr), .dbg_l1_valid(dbg_l1_valid),
    .dbg_l2_addr(dbg_l2_addr), .dbg_l2_valid(dbg_l2_valid));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find(ref logic [AW-1:0] q[$], input logic [AW-1:0] a);
    foreach (q[k]) if (q[k] == a) return k;
    return -1;
  endfunction

  task automatic touch(ref logic [AW-1:0] q[$], input logic [AW-1:0] a, input int w, output bit evicted);
    int k = find(q, a);
    evicted = 0;
    if (k >= 0) q.delete(k);
    q.push_front(a);
    if (q.size() > w) begin void'(q.pop_back()); evicted = 1; end
  endtask

  task automatic cmp_level(input string req, ref logic [AW-1:0] q[$], input int w,
                           input logic [63:0] aflat, input logic [7:0] vflat);
    logic [63:0] ea = '0, ma = '0;
    logic [7:0]  ev = '0;
    for (int k = 0; k < w; k++) begin
      if (k < q.size()) begin
        ev[k] = 1'b1;
        ea[k*AW +: AW] = q[k];
        ma[k*AW +: AW] = aflat[k*AW +: AW];
      end
    end
    check(vflat == ev, {req, " valid"}, 64'(vflat), 64'(ev));
    check(ma == ea, {req, " order"}, ma, ea);
  endtask

  task automatic step(input bit vld, input logic [AW-1:0] a, input string tag);
    int kind = 0;
    bit e1 = 0, e2 = 0;
    logic [AW-1:0] old2[$];
    string r1 = "R8", r2 = "R8";
    old2 = q2;
    req_valid = vld;
    req_addr  = a;
    if (vld) begin
      if (find(q1, a) >= 0) begin
        kind = 1;
        touch(q1, a, W1, e1);
        r2 = "R2 l2 untouched";
      end else begin
        kind = (find(q2, a) >= 0) ? 2 : 3;
        touch(q1, a, W1, e1);
        touch(q2, a, W2, e2);
        r2 = (kind == 2) ? "R4" : "R5";
      end
      if (e1) r1 = "R6 l1 evict";
      if (e2) r2 = "R6 l2 evict";
      if (!e1 && q1.size() < W1) r1 = "R7 l1 fill";
    end else begin
      r1 = "R9 idle l1";
      r2 = "R9 idle l2";
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check({rsp_valid, rsp_l1_hit, rsp_l2_hit, rsp_miss} ==
          {vld, kind == 1, kind == 2, kind == 3},
          $sformatf("R3 outcome %s", tag),
          64'({rsp_valid, rsp_l1_hit, rsp_l2_hit, rsp_miss}),
          64'({vld, kind == 1, kind == 2, kind == 3}));
    cmp_level({r1, " ", tag}, q1, W1, 64'(dbg_l1_addr), 8'(dbg_l1_valid));
    cmp_level({r2, " ", tag}, q2, W2, 64'(dbg_l2_addr), 8'(dbg_l2_valid));
    if (kind == 1)
      check(q2 == old2, "R2 l2 model stable", 64'(dbg_l2_addr), 64'(dbg_l2_addr));
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1c));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check(dbg_l1_valid == '0 && dbg_l2_valid == '0, "R1 empty after reset",
          64'({dbg_l1_valid, dbg_l2_valid}), 64'(0));
    check(!rsp_valid && !rsp_l1_hit && !rsp_l2_hit && !rsp_miss, "R3 quiet after reset",
          64'({rsp_valid, rsp_l1_hit, rsp_l2_hit, rsp_miss}), 64'(0));

    step(1, 16'h00A0, "A cold");
    step(1, 16'h00B0, "B cold");
    step(1, 16'h00A0, "A l1 hit");
    step(0, 16'h00C0, "idle");
    step(1, 16'h00C0, "C cold");
    step(1, 16'h00B0, "B l2 hit");
    step(1, 16'h00D0, "D evicts");
    step(1, 16'h00A0, "A after drops");
    step(1, 16'h00C0, "C victim back");
    step(1, 16'h00C0, "C repeat");
    step(1, 16'hFFFF, "top address");
    step(1, 16'h0000, "zero address");
    step(0, 16'h0000, "idle zero");

    for (int n = 0; n < 600; n++) begin
      bit v = ($urandom_range(0, 9) < 8);
      logic [AW-1:0] a = 16'h1000 + AW'($urandom_range(0, 5));
      step(v, a, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule